// File: doc/BRIEF.md
# SPI Transmit Buffer Write Collision Guard

This block sits between a CPU write port and the shift register of an SPI-style serial port. The port can run as master or slave, with either clock phase. The block decides, cycle by cycle, whether a transfer is in progress. The rule it uses depends on the master/slave mode and on the clock phase.

A CPU write that arrives while a transfer is in progress is a collision. It raises a sticky collision flag, and the data is kept in a readable buffer register. The shift register is not loaded, so the transfer on the wire completes as if the write never happened. A write outside a transfer loads the shift register and refreshes the same readable buffer.

The block also produces the output enable for the serial data line, which must stay released in slave mode unless the port is both selected and allowed to transmit. The shift engine and the bit clock live elsewhere. Their first-clock-edge and last-sample-edge events arrive here as single-cycle strobes.

Top module: `spi_wcol_guard`

## Requirements
- R1: In master mode with clock phase 0, `xfer_busy` goes to 1 in the cycle after a write that loads the shift register, and it returns to 0 in the cycle after a `last_edge` strobe.
- R2: In master mode with clock phase 1, a loading write leaves `xfer_busy` at 0. `xfer_busy` goes to 1 in the cycle after a `first_edge` strobe and returns to 0 in the cycle after a `last_edge` strobe.
- R3: In slave mode with clock phase 0, `xfer_busy` is 1 exactly while `sel_n` is 0.
- R4: In slave mode with clock phase 1, `xfer_busy` follows the `first_edge` and `last_edge` strobes as in R2, whatever `sel_n` does.
- R5: A write (`cpu_wr` = 1) seen while `xfer_busy` is 1 sets `wcol` from the next cycle. `wcol` stays 1 until a cycle with `wcol_clr` = 1 and no new collision. If a collision and `wcol_clr` arrive together, the flag is set.
- R6: A colliding write produces no `shift_load` pulse and leaves `shift_data` unchanged.
- R7: Every write, colliding or not, updates `rd_buf` to the written data from the next cycle.
- R8: A write seen while `xfer_busy` is 0 gives a one-cycle `shift_load` pulse in the next cycle, with `shift_data` equal to the written data.
- R9: A write made in the cycle right after a `last_edge` strobe is not a collision.
- R10: `sdo_oe` is 1 in master mode. In slave mode it is 1 only when `sel_n` = 0 and `tx_en` = 1.
- R11: After reset, `wcol`, `shift_load`, `xfer_busy` (outside slave phase-0 selection), `rd_buf` and `shift_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| cpha | input | 1 | Clock phase select |
| sel_n | input | 1 | Slave select, active low |
| tx_en | input | 1 | Transmit enable for slave mode |
| cpu_wr | input | 1 | CPU write strobe to the transmit buffer |
| cpu_wdata | input | DATA_W | CPU write data |
| first_edge | input | 1 | Strobe: first serial clock edge of a transfer |
| last_edge | input | 1 | Strobe: last sample edge of a transfer |
| wcol_clr | input | 1 | Clears the collision flag |
| xfer_busy | output | 1 | Transfer in progress |
| wcol | output | 1 | Sticky write collision flag |
| rd_buf | output | DATA_W | Readable buffer, the last written data |
| shift_load | output | 1 | One-cycle load strobe to the shift register |
| shift_data | output | DATA_W | Data for the shift register |
| sdo_oe | output | 1 | Output enable of the serial data line |

## Verification
The main stimulus walks all four combinations of mode and clock phase. In each one it writes once outside a transfer and once inside it. This separates the rules for opening the window: a loading write (master, phase 0), a first-edge strobe (phase 1), and the select level (slave, phase 0). A write placed in the cycle right after the last-edge strobe shows where the window closes. Writes made with the flag already set, and a clear made on its own, show that the flag is sticky and can be cleared. Directed cases then cover a clear that coincides with a new collision, a check that the shift data does not move during a collision, and every select/enable combination of the output enable.

// File: rtl/spi_wcol_pkg.sv
package spi_wcol_pkg;

    typedef enum logic [1:0] {
        WIN_M_PH0 = 2'd0,
        WIN_M_PH1 = 2'd1,
        WIN_S_PH0 = 2'd2,
        WIN_S_PH1 = 2'd3
    } win_mode_e;

    function automatic win_mode_e pick_window(input logic master, input logic phase);
        case ({master, phase})
            2'b10:   return WIN_M_PH0;
            2'b11:   return WIN_M_PH1;
            2'b00:   return WIN_S_PH0;
            default: return WIN_S_PH1;
        endcase
    endfunction

endpackage

// File: rtl/spi_wcol_window.sv
module spi_wcol_window
    import spi_wcol_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic cpha,
    input  logic sel_n,
    input  logic cpu_wr,
    input  logic first_edge,
    input  logic last_edge,
    output logic busy
);

    typedef struct packed {
        logic run;
    } win_state_t;

    win_state_t st_d, st_q;
    win_mode_e  mode;
    logic       load_go;

    always_comb begin
        mode = pick_window(is_master, cpha);
        busy = (mode == WIN_S_PH0) ? ~sel_n : st_q.run;
        load_go = cpu_wr & ~busy;
        st_d = st_q;
        if (mode == WIN_M_PH0 && load_go) st_d.run = 1'b1;
        if (first_edge)                   st_d.run = 1'b1;
        if (last_edge)                    st_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: in master phase-0 mode a loading write opens the window
    p_load_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !cpha && cpu_wr && !busy && !last_edge) |=> st_q.run);

    // R2 / R4: a last-edge strobe closes the window
    p_last_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_edge |=> !st_q.run);

    // R3: in slave phase-0 mode busy mirrors the select line
    p_slave_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !cpha) |-> (busy == !sel_n));

endmodule

// File: rtl/spi_wcol_capture.sv
module spi_wcol_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              wcol_clr,
    output logic              wcol,
    output logic [DATA_W-1:0] rd_buf,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data
);

    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] buf_val;
        logic              load;
        logic [DATA_W-1:0] sh_val;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit  = cpu_wr & busy;
        st_d = st_q;
        st_d.load = 1'b0;
        if (wcol_clr) st_d.flag = 1'b0;
        if (hit)      st_d.flag = 1'b1;
        if (cpu_wr)   st_d.buf_val = cpu_wdata;
        if (cpu_wr && !busy) begin
            st_d.load   = 1'b1;
            st_d.sh_val = cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wcol       = st_q.flag;
    assign rd_buf     = st_q.buf_val;
    assign shift_load = st_q.load;
    assign shift_data = st_q.sh_val;

    // R5: the flag holds until cleared
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !wcol_clr) |=> wcol);

    // R5: a write inside the window raises the flag
    p_hit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && busy) |=> wcol);

    // R6: a colliding write never loads the shift register
    p_no_load_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && busy) |=> (!shift_load && $stable(shift_data)));

    // R7: the readable buffer follows every write
    p_buf_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (rd_buf == $past(cpu_wdata)));

    // R8: a load strobe lasts one cycle
    p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_load && !$past(cpu_wr)) |-> 1'b0);

endmodule

// File: rtl/spi_wcol_drive.sv
module spi_wcol_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic sel_n,
    input  logic tx_en,
    output logic sdo_oe
);

    always_comb begin
        sdo_oe = is_master | (~sel_n & tx_en);
    end

    // R10: an unselected slave releases the data line
    p_slave_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && (sel_n || !tx_en)) |-> !sdo_oe);

endmodule

// File: rtl/spi_wcol_guard.sv
module spi_wcol_guard #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              cpha,
    input  logic              sel_n,
    input  logic              tx_en,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              first_edge,
    input  logic              last_edge,
    input  logic              wcol_clr,
    output logic              xfer_busy,
    output logic              wcol,
    output logic [DATA_W-1:0] rd_buf,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data,
    output logic              sdo_oe
);

    logic busy_w;

    spi_wcol_window u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_master  (is_master),
        .cpha       (cpha),
        .sel_n      (sel_n),
        .cpu_wr     (cpu_wr),
        .first_edge (first_edge),
        .last_edge  (last_edge),
        .busy       (busy_w)
    );

    spi_wcol_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy_w),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .wcol_clr   (wcol_clr),
        .wcol       (wcol),
        .rd_buf     (rd_buf),
        .shift_load (shift_load),
        .shift_data (shift_data)
    );

    spi_wcol_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .sel_n     (sel_n),
        .tx_en     (tx_en),
        .sdo_oe    (sdo_oe)
    );

    assign xfer_busy = busy_w;

    // R9: the cycle after a last-edge strobe is outside a phase-1 or master window
    p_after_last_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_edge && !first_edge && !(!is_master && !cpha)) |=>
        (!(!is_master && !cpha) -> !xfer_busy));

endmodule

// File: tb/spi_wcol_guard_test.sv
module spi_wcol_guard_test;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b1, cpha = 1'b0, sel_n = 1'b1, tx_en = 1'b0;
    logic cpu_wr = 1'b0, first_edge = 1'b0, last_edge = 1'b0, wcol_clr = 1'b0;
    logic [W-1:0] cpu_wdata = '0;
    logic xfer_busy, wcol, shift_load, sdo_oe;
    logic [W-1:0] rd_buf, shift_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_wcol_guard #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .cpha(cpha),
        .sel_n(sel_n), .tx_en(tx_en), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .first_edge(first_edge), .last_edge(last_edge), .wcol_clr(wcol_clr),
        .xfer_busy(xfer_busy), .wcol(wcol), .rd_buf(rd_buf),
        .shift_load(shift_load), .shift_data(shift_data), .sdo_oe(sdo_oe)
    );

    typedef struct packed {
        logic m, cp, ssn, fe, le, wr;
        logic [7:0] d;
        logic clr;
        logic eb, ew, el;
        logic [7:0] ebuf;
    } vec_t;

    localparam int NV = 17;
    // master phase 0 (R1, R5, R6, R9), master phase 1 (R2),
    // slave phase 0 (R3), slave phase 1 (R4)
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,8'hA5,1'b0, 1'b1,1'b0,1'b1,8'hA5},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,8'h3C,1'b0, 1'b1,1'b1,1'b0,8'h3C},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b0,8'h3C},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,8'h77,1'b0, 1'b1,1'b1,1'b1,8'h77},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,8'h77},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,8'h11,1'b0, 1'b0,1'b0,1'b1,8'h11},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,8'h11},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,8'h22,1'b0, 1'b1,1'b1,1'b0,8'h22},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,8'h22},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,8'h22},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h44,1'b0, 1'b1,1'b1,1'b0,8'h44},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,8'h44},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h55,1'b0, 1'b0,1'b0,1'b1,8'h55},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b0,8'h55},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h66,1'b0, 1'b1,1'b1,1'b0,8'h66},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b0,8'h66},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h88,1'b0, 1'b0,1'b1,1'b1,8'h88}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check("R11 wcol", wcol, 0);
        check("R11 load", shift_load, 0);
        check("R11 busy", xfer_busy, 0);
        check("R11 rd_buf", rd_buf, 0);
        check("R11 shift_data", shift_data, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            is_master = VEC[i].m;  cpha = VEC[i].cp; sel_n = VEC[i].ssn;
            first_edge = VEC[i].fe; last_edge = VEC[i].le; cpu_wr = VEC[i].wr;
            cpu_wdata = VEC[i].d; wcol_clr = VEC[i].clr;
            @(posedge clk);
            #1;
            first_edge = 1'b0; last_edge = 1'b0; cpu_wr = 1'b0; wcol_clr = 1'b0;
            // R1 R2 R3 R4 window, R5 flag, R6/R8 load, R7 buffer, R9 after last edge
            check($sformatf("R1-window busy row %0d", i), xfer_busy, VEC[i].eb);
            check($sformatf("R5 wcol row %0d", i), wcol, VEC[i].ew);
            check($sformatf("R8 load row %0d", i), shift_load, VEC[i].el);
            check($sformatf("R7 rd_buf row %0d", i), rd_buf, VEC[i].ebuf);
            if (VEC[i].el) check($sformatf("R8 shift_data row %0d", i), shift_data, VEC[i].d);
        end

        // R5: clear and collision in the same cycle, set wins
        @(negedge clk);
        is_master = 1'b1; cpha = 1'b1; first_edge = 1'b1; wcol_clr = 1'b1;
        @(posedge clk); #1;
        first_edge = 1'b0;
        check("R5 clear-alone", wcol, 0);
        held = shift_data;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = 8'hC3; wcol_clr = 1'b1;
        @(posedge clk); #1;
        cpu_wr = 1'b0; wcol_clr = 1'b0;
        check("R5 set beats clear", wcol, 1);
        // R6: no load and shift data untouched
        check("R6 no load", shift_load, 0);
        check("R6 shift_data held", shift_data, held);
        check("R7 shadow", rd_buf, 8'hC3);
        @(negedge clk);
        check("R5 held", wcol, 1);

        // R10: output enable
        is_master = 1'b1; sel_n = 1'b1; tx_en = 1'b0; #1;
        check("R10 master", sdo_oe, 1);
        is_master = 1'b0; sel_n = 1'b0; tx_en = 1'b1; #1;
        check("R10 slave sel en", sdo_oe, 1);
        sel_n = 1'b0; tx_en = 1'b0; #1;
        check("R10 slave sel no-en", sdo_oe, 0);
        sel_n = 1'b1; tx_en = 1'b1; #1;
        check("R10 slave unsel", sdo_oe, 0);

        finish_run();
    end

endmodule